// File: doc/BRIEF.md
# Serial Zero-Then-Three-Ones Recognizer

This block watches a serial bit stream, one bit per clock when a valid qualifier is high, and flags the moment the stream ends in a zero followed by three ones (oldest bit first). It is a four-state Mealy machine. The flag depends on the registered state and the bit arriving in the same cycle, so a match is reported on the cycle that carries the final one.

The two-bit state code is brought out for observation. The code is 00 at the start, 01 after a zero, 10 after zero-one, and 11 after zero-one-one. A cycle with the qualifier low is not counted as a bit. A parameter selects a registered flag, which asserts one cycle after the completing bit instead of in the same cycle.

Top module: `serial_run_detector`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the match output is 0. After the edge that samples reset high, the state code is 00.
- R2: The state code is two bits wide with a fixed binary meaning: 00 start, 01 saw a zero, 10 saw zero-one, 11 saw zero-one-one.
- R3: A valid 0 moves the machine from any state to 01, and the match output stays 0.
- R4: A valid 1 received in state 00 leaves the state at 00, and the match output stays 0.
- R5: A valid 1 moves 01 to 10 and moves 10 to 11, and the match output stays 0 on both steps.
- R6: A valid 1 received in state 11 drives the match output to 1 in that same cycle, and the next state is 00.
- R7: While the valid qualifier is low, the state holds and the match output is 0, whatever the data bit is.
- R8: Over any stream, the match output (with REG_MATCH=0) is 1 exactly when the bit is valid and the last four valid bits since reset, oldest first, are 0,1,1,1.
- R9: With REG_MATCH=1, the match output shows one cycle later the value the combinational flag would have had. Reset clears it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bitValid | input | 1 | High when bitIn carries a stream bit this cycle |
| bitIn | input | 1 | Serial data bit |
| matchOut | output | 1 | Pattern-complete flag, combinational or registered depending on REG_MATCH |
| stateCode | output | 2 | Current state code for observation |

## Verification
A directed table walks every state and applies both bit values in each. This separates the rule that a zero always returns to 01 from the rule that a one in the start state stays put. It also checks that the completing one goes straight to 00 and not to 01. Idle cycles are inserted mid-pattern, with both data values, to show that they neither advance nor break a partial match. A reset is applied in state 11 with a one present, to show that the flag stays low during reset. Long random streams with random gaps are then compared against a history of the last four valid bits. This catches any wrong transition that only a particular mix of bits reaches. A second instance with the registered flag confirms the one-cycle delay.

// File: rtl/srd_pkg.sv
package srd_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE   = 2'b00,
    ST_SAW0   = 2'b01,
    ST_SAW01  = 2'b10,
    ST_SAW011 = 2'b11
  } srdState_e;

  typedef struct packed {
    logic      advance;
    srdState_e nextState;
    logic      hit;
  } srdStrobe_t;

endpackage

// File: rtl/srd_ctrl.sv
module srd_ctrl
  import srd_pkg::*;
(
  input  logic       rst,
  input  logic       bitValid,
  input  logic       bitIn,
  input  srdState_e  curState,
  output srdStrobe_t strobe
);

  srdState_e onOne;

  // successor when a one arrives
  always_comb begin
    case (curState)
      ST_IDLE:   onOne = ST_IDLE;
      ST_SAW0:   onOne = ST_SAW01;
      ST_SAW01:  onOne = ST_SAW011;
      default:   onOne = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.advance   = bitValid;
    strobe.nextState = bitIn ? onOne : ST_SAW0;
    strobe.hit       = bitValid && bitIn && !rst && (curState == ST_SAW011);
  end

endmodule

// File: rtl/srd_dpath.sv
module srd_dpath
  import srd_pkg::*;
#(
  parameter bit REG_MATCH = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  srdStrobe_t strobe,
  output srdState_e  curState,
  output logic       matchOut
);

  always_ff @(posedge clk) begin
    if (rst)                 curState <= ST_IDLE;
    else if (strobe.advance) curState <= strobe.nextState;
  end

  generate
    if (REG_MATCH) begin : gRegMatch
      logic hitQ;
      always_ff @(posedge clk) begin
        if (rst) hitQ <= 1'b0;
        else     hitQ <= strobe.hit;
      end
      assign matchOut = hitQ;

      // R9: registered flag lags the combinational hit by one cycle
      assert_lagHigh_R9: assert property (@(posedge clk) disable iff (rst)
        strobe.hit |=> matchOut);
      assert_lagLow_R9: assert property (@(posedge clk) disable iff (rst)
        !strobe.hit |=> !matchOut);
    end else begin : gCombMatch
      assign matchOut = strobe.hit;
    end
  endgenerate

endmodule

// File: rtl/serial_run_detector.sv
module serial_run_detector
  import srd_pkg::*;
#(
  parameter bit REG_MATCH = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bitValid,
  input  logic               bitIn,
  output logic               matchOut,
  output logic [STATE_W-1:0] stateCode
);

  srdStrobe_t strobe;
  srdState_e  curState;

  srd_ctrl uCtrl (
    .rst      (rst),
    .bitValid (bitValid),
    .bitIn    (bitIn),
    .curState (curState),
    .strobe   (strobe)
  );

  srd_dpath #(.REG_MATCH(REG_MATCH)) uDpath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .curState (curState),
    .matchOut (matchOut)
  );

  assign stateCode = curState;

  assert_resetState_R1: assert property (@(posedge clk)
    rst |=> stateCode == 2'b00);
  assert_resetQuiet_R1: assert property (@(posedge clk)
    rst |-> !strobe.hit);
  assert_zeroGoes01_R3: assert property (@(posedge clk) disable iff (rst)
    (bitValid && !bitIn) |=> stateCode == 2'b01);
  assert_oneAtStart_R4: assert property (@(posedge clk) disable iff (rst)
    (bitValid && bitIn && stateCode == 2'b00) |=> stateCode == 2'b00);
  assert_climbA_R5: assert property (@(posedge clk) disable iff (rst)
    (bitValid && bitIn && stateCode == 2'b01) |=> stateCode == 2'b10);
  assert_climbB_R5: assert property (@(posedge clk) disable iff (rst)
    (bitValid && bitIn && stateCode == 2'b10) |=> stateCode == 2'b11);
  assert_hitReturns_R6: assert property (@(posedge clk) disable iff (rst)
    strobe.hit |=> stateCode == 2'b00);
  assert_idleHold_R7: assert property (@(posedge clk) disable iff (rst)
    !bitValid |=> $stable(stateCode));
  assert_idleQuiet_R7: assert property (@(posedge clk) disable iff (rst)
    !bitValid |-> !strobe.hit);

endmodule

// File: tb/tb_serial_run_detector.sv
module tb_serial_run_detector;

  logic clk = 1'b0;
  logic rst, bitValid, bitIn;
  logic matchOut, matchReg;
  logic [1:0] stateCode, stateReg;

  int applied = 0;
  int fails = 0;

  always #10 clk = ~clk;

  serial_run_detector #(.REG_MATCH(1'b0)) dut (
    .clk(clk), .rst(rst), .bitValid(bitValid), .bitIn(bitIn),
    .matchOut(matchOut), .stateCode(stateCode));

  serial_run_detector #(.REG_MATCH(1'b1)) dutReg (
    .clk(clk), .rst(rst), .bitValid(bitValid), .bitIn(bitIn),
    .matchOut(matchReg), .stateCode(stateReg));

  // row: {rst, valid, bit, expMatch, expNext[1:0]}
  localparam int NV = 23;
  localparam logic [5:0] VEC [0:NV-1] = '{
    6'b0_1_1_0_00, 6'b0_1_0_0_01, 6'b0_1_1_0_10, 6'b0_0_1_0_10,
    6'b0_1_1_0_11, 6'b0_0_0_0_11, 6'b0_1_1_1_00, 6'b0_1_1_0_00,
    6'b0_1_0_0_01, 6'b0_1_0_0_01, 6'b0_1_1_0_10, 6'b0_1_0_0_01,
    6'b0_1_1_0_10, 6'b0_1_1_0_11, 6'b0_1_0_0_01, 6'b0_1_1_0_10,
    6'b0_1_1_0_11, 6'b0_1_1_1_00, 6'b0_1_0_0_01, 6'b0_1_1_0_10,
    6'b0_1_1_0_11, 6'b1_1_1_0_00, 6'b0_1_1_0_00
  };

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    applied++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive at negedge, check comb flag, clock, check state and registered flag
  task automatic step(input logic r, input logic v, input logic b,
                      input logic expM, input logic [1:0] expS, input string tag);
    @(negedge clk);
    rst = r; bitValid = v; bitIn = b;
    #1;
    check({tag, " match"}, {1'b0, matchOut}, {1'b0, expM});
    @(posedge clk);
    #1;
    check({tag, " R2 state"}, stateCode, expS);
    check("R9 registered match", {1'b0, matchReg}, {1'b0, expM});
  endtask

  function automatic string rowTag(input logic [5:0] row, input logic [1:0] prev);
    if (row[5]) return "R1";
    if (!row[4]) return "R7";
    if (row[2]) return "R6";
    if (!row[3]) return "R3";
    if (prev == 2'b00) return "R4";
    return "R5";
  endfunction

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    logic [1:0] prevS;
    logic [3:0] hist;
    logic [1:0] expS;
    logic expM;
    rst = 1'b1; bitValid = 1'b1; bitIn = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset match", {1'b0, matchOut}, 2'b00);
    check("R1 reset state", stateCode, 2'b00);

    // directed table
    prevS = 2'b00;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1:0],
           rowTag(VEC[i], prevS));
      prevS = VEC[i][1:0];
    end

    // R8: random streams against a history of the last four valid bits
    hist = 4'b1111;
    for (int n = 0; n < 4000; n++) begin
      logic v, b;
      v = ($urandom % 4) != 0;
      b = ($urandom % 3) != 0;
      expM = v && ({hist[2:0], b} == 4'b0111);
      if (v) hist = {hist[2:0], b};
      if (!hist[0])                 expS = 2'b01;
      else if (hist[1:0] == 2'b01)  expS = 2'b10;
      else if (hist[2:0] == 3'b011) expS = 2'b11;
      else                          expS = 2'b00;
      step(1'b0, v, b, expM, expS, "R8");
    end

    // reset in state 11 with a one waiting
    step(1'b0, 1'b1, 1'b0, 1'b0, 2'b01, "R3");
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'b10, "R5");
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, "R5");
    step(1'b1, 1'b1, 1'b1, 1'b0, 2'b00, "R1");
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

endmodule